// File: doc/BRIEF.md
# Prioritized Interrupt Vector Fetch Unit

This unit carries out the vector-select instruction of a small 8-bit controller core. When the instruction decoder pulses the start strobe, the unit does three things. First, it freezes the pending interrupt request lines and picks the request with the best rank. It turns that rank into an even offset inside the 256-byte page that holds the vector table. The upper byte of the program counter picks that page and is kept as it is. The unit then reads the two vector bytes from program memory through a synchronous read port with one cycle of latency. Finally, it gives the 16-bit result to the program counter for one cycle and reports that it is done.

Sixteen slots are ranked. Slot 1 is the highest and slot 16 is the default entry, which is used when no usable request is pending. A slot whose source is reserved keeps its place in the ranking but can never win. A separate pending flag for the non-maskable source sits beside the sequencer. A set input raises it. Reset or a clear input lowers it. A vector fetch leaves it alone.

The sequencer has five states, visited in a fixed order. IDLE waits for the start strobe. SAMPLE puts the even table address on the memory port. READ_HI takes in the high byte and puts the odd address on the port. READ_LO takes in the low byte. LOAD drives the program counter load and done for exactly one cycle. The transitions are IDLE to SAMPLE on start, then SAMPLE to READ_HI, READ_HI to READ_LO, READ_LO to LOAD and LOAD to IDLE. The last four happen on every clock with no condition.

Top module: `vecfetch_unit`

## Requirements
- R1: Request bit i of `req_i` stands for rank i+1, so bit 0 is rank 1 and is the highest. The chosen rank on `dbg_rank_o` is the lowest-numbered rank whose bit is set and whose slot is not reserved. If there is no such bit, the chosen rank is 16.
- R2: The table offset on `dbg_off_o` equals 0x100 minus twice the chosen rank. It is therefore always even and lies between 0xE0 and 0xFE. The default rank 16 gives 0xE0.
- R3: Ranks 2, 12, 13 and 14 are reserved (request bits 1, 11, 12 and 13). A request on a reserved bit never changes the chosen rank or the offset.
- R4: The rank is decided from `req_i` in the cycle in which start is accepted. A later change on `req_i` has no effect on the rank or the addresses of that fetch.
- R5: The first read address is {pc_i[15:8] at start, offset}. The second read address is the same address with bit 0 set. A change on `pc_i` after start has no effect.
- R6: The byte at the even address is the high byte of the vector and the byte at the odd address is the low byte. `pc_new_o` shows {high, low} while `pc_load_o` is high.
- R7: Call the cycle in which start is accepted cycle c. `mem_rd_o` is high in cycles c+1 and c+2 only. `pc_load_o` and `done_o` are high together in cycle c+4 only.
- R8: A start strobe is accepted only in IDLE. A strobe held during cycles c+1 to c+4 starts no second fetch and changes no result.
- R9: `nmi_set_i` raises `nmi_pend_o` on the next cycle. `nmi_clr_i` lowers it on the next cycle and wins over a set in the same cycle. A vector fetch does not change it.
- R10: After reset the unit is in IDLE. `mem_rd_o`, `pc_load_o`, `done_o` and `nmi_pend_o` are low, `dbg_rank_o` is 16 and `dbg_off_o` is 0xE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe from the instruction decoder |
| req_i | input | 15 | Active interrupt requests; bit i is rank i+1 |
| pc_i | input | 16 | Current program counter; the upper byte selects the table page |
| mem_data_i | input | 8 | Read data from program memory, one cycle after the address |
| nmi_set_i | input | 1 | Raises the non-maskable pending flag |
| nmi_clr_i | input | 1 | Clear-pending instruction input |
| mem_rd_o | output | 1 | Read request to program memory |
| mem_addr_o | output | 16 | Read address to program memory |
| pc_load_o | output | 1 | One-cycle program counter load |
| pc_new_o | output | 16 | Fetched vector for the program counter |
| done_o | output | 1 | Fetch complete, high with `pc_load_o` |
| nmi_pend_o | output | 1 | Non-maskable pending flag |
| dbg_rank_o | output | 5 | Rank of the last selection, 1 to 16 |
| dbg_off_o | output | 8 | Table offset of the last selection |

## Verification
Cycle c is the cycle in which start is accepted. The rank and offset outputs settle one cycle later, at c+1. The even address is on the port at c+1 and the odd address at c+2. The port is quiet at c+3. The vector, load and done appear at c+4. At c+5 the unit is idle again. The bench drives each input on a falling edge and reads each of these results on the falling edge of exactly the cycle in which it is due. It works out the expected rank, offset, addresses and vector bytes from a ranking function and a memory contents formula of its own. Each sweep step changes the requests and the program counter and raises start again at c+1, so that the frozen decision and the busy lockout are checked in the same cycles as the main results.

// File: rtl/vf_pkg.sv
package vf_pkg;

    // Sequencer states, visited in this fixed order for each fetch.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SAMPLE  = 3'd1,
        ST_READ_HI = 3'd2,
        ST_READ_LO = 3'd3,
        ST_LOAD    = 3'd4
    } vf_state_e;

endpackage

// File: rtl/vf_rank_select.sv
module vf_rank_select #(
    parameter int               NUM_SRC   = 15,
    parameter logic [NUM_SRC-1:0] RSVD_MASK = 15'h3802,
    parameter int               RANK_W    = 5,
    parameter int               OFF_W     = 8,
    parameter int               TOP_OFF   = 'hFE
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic [RANK_W-1:0]  rank_o,
    output logic [OFF_W-1:0]   off_o
);

    localparam int DEF_RANK = NUM_SRC + 1;

    logic [NUM_SRC-1:0] usable;

    // Reserved slots are tied low so they keep their rank but never win.
    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_slot
            if (RSVD_MASK[g]) begin : g_rsvd
                assign usable[g] = 1'b0;
            end else begin : g_live
                assign usable[g] = req_i[g];
            end
        end
    endgenerate

    // Scan from the lowest rank to the highest, so the best rank is written last.
    always_comb begin
        rank_o = RANK_W'(DEF_RANK);
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (usable[i]) begin
                rank_o = RANK_W'(i + 1);
            end
        end
    end

    // Each step down in rank moves the slot two bytes lower in the page.
    always_comb begin
        off_o = OFF_W'(TOP_OFF + 2 - 2 * int'(rank_o));
    end

endmodule

// File: rtl/vf_pend_flag.sv
module vf_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    // Clear wins over set; the fetch sequence has no path into this flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
        end else if (clr_i) begin
            pend_o <= 1'b0;
        end else if (set_i) begin
            pend_o <= 1'b1;
        end
    end

endmodule

// File: rtl/vf_seq_fsm.sv
module vf_seq_fsm
    import vf_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int OFF_W    = 8,
    parameter int DATA_W   = 8,
    parameter int RANK_W   = 5,
    parameter int DEF_RANK = 16,
    parameter int DEF_OFF  = 'hE0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [PC_W-OFF_W-1:0]  page_i,
    input  logic [RANK_W-1:0]      sel_rank_i,
    input  logic [OFF_W-1:0]       sel_off_i,
    input  logic [DATA_W-1:0]      mem_data_i,
    output logic                   mem_rd_o,
    output logic [PC_W-1:0]        mem_addr_o,
    output logic                   pc_load_o,
    output logic                   done_o,
    output logic [2*DATA_W-1:0]    pc_new_o,
    output logic [RANK_W-1:0]      dbg_rank_o,
    output logic [OFF_W-1:0]       dbg_off_o
);

    localparam int PAGE_W = PC_W - OFF_W;

    vf_state_e            state_q, state_d;
    logic [PAGE_W-1:0]    page_q;
    logic [RANK_W-1:0]    rank_q;
    logic [OFF_W-1:0]     off_q;
    logic [DATA_W-1:0]    vhi_q, vlo_q;
    logic                 accept;

    assign accept = (state_q == ST_IDLE) && start_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = start_i ? ST_SAMPLE : ST_IDLE;
            ST_SAMPLE:  state_d = ST_READ_HI;
            ST_READ_HI: state_d = ST_READ_LO;
            ST_READ_LO: state_d = ST_LOAD;
            ST_LOAD:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Datapath registers: selection frozen at accept, vector bytes as they return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            rank_q <= RANK_W'(DEF_RANK);
            off_q  <= OFF_W'(DEF_OFF);
            vhi_q  <= '0;
            vlo_q  <= '0;
        end else begin
            if (accept) begin
                page_q <= page_i;
                rank_q <= sel_rank_i;
                off_q  <= sel_off_i;
            end
            if (state_q == ST_READ_HI) begin
                vhi_q <= mem_data_i;
            end
            if (state_q == ST_READ_LO) begin
                vlo_q <= mem_data_i;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_rd_o   = 1'b0;
        mem_addr_o = {page_q, off_q};
        pc_load_o  = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_SAMPLE: begin
                mem_rd_o = 1'b1;
            end
            ST_READ_HI: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = {page_q, off_q[OFF_W-1:1], 1'b1};
            end
            ST_READ_LO: begin
            end
            ST_LOAD: begin
                pc_load_o = 1'b1;
                done_o    = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign pc_new_o   = {vhi_q, vlo_q};
    assign dbg_rank_o = rank_q;
    assign dbg_off_o  = off_q;

endmodule

// File: rtl/vecfetch_unit.sv
module vecfetch_unit #(
    parameter int                 NUM_SRC   = 15,
    parameter logic [NUM_SRC-1:0] RSVD_MASK = 15'h3802,
    parameter int                 PC_W      = 16,
    parameter int                 DATA_W    = 8,
    parameter int                 TOP_OFF   = 'hFE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [DATA_W-1:0]  mem_data_i,
    input  logic               nmi_set_i,
    input  logic               nmi_clr_i,
    output logic               mem_rd_o,
    output logic [PC_W-1:0]    mem_addr_o,
    output logic               pc_load_o,
    output logic [PC_W-1:0]    pc_new_o,
    output logic               done_o,
    output logic               nmi_pend_o,
    output logic [$clog2(NUM_SRC+2)-1:0] dbg_rank_o,
    output logic [DATA_W-1:0]  dbg_off_o
);

    localparam int OFF_W    = DATA_W;
    localparam int PAGE_W   = PC_W - OFF_W;
    localparam int RANK_W   = $clog2(NUM_SRC + 2);
    localparam int DEF_RANK = NUM_SRC + 1;
    localparam int DEF_OFF  = TOP_OFF + 2 - 2 * DEF_RANK;

    logic [RANK_W-1:0] sel_rank;
    logic [OFF_W-1:0]  sel_off;

    vf_rank_select #(
        .NUM_SRC   (NUM_SRC),
        .RSVD_MASK (RSVD_MASK),
        .RANK_W    (RANK_W),
        .OFF_W     (OFF_W),
        .TOP_OFF   (TOP_OFF)
    ) u_rank (
        .req_i  (req_i),
        .rank_o (sel_rank),
        .off_o  (sel_off)
    );

    vf_seq_fsm #(
        .PC_W     (PC_W),
        .OFF_W    (OFF_W),
        .DATA_W   (DATA_W),
        .RANK_W   (RANK_W),
        .DEF_RANK (DEF_RANK),
        .DEF_OFF  (DEF_OFF)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .page_i     (pc_i[PC_W-1 -: PAGE_W]),
        .sel_rank_i (sel_rank),
        .sel_off_i  (sel_off),
        .mem_data_i (mem_data_i),
        .mem_rd_o   (mem_rd_o),
        .mem_addr_o (mem_addr_o),
        .pc_load_o  (pc_load_o),
        .done_o     (done_o),
        .pc_new_o   (pc_new_o),
        .dbg_rank_o (dbg_rank_o),
        .dbg_off_o  (dbg_off_o)
    );

    vf_pend_flag u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (nmi_set_i),
        .clr_i  (nmi_clr_i),
        .pend_o (nmi_pend_o)
    );

endmodule

// File: rtl/vecfetch_unit_chk.sv
module vecfetch_unit_chk #(
    parameter int PC_W    = 16,
    parameter int DATA_W  = 8,
    parameter int RANK_W  = 5,
    parameter int MAX_RNK = 16,
    parameter int LOW_OFF = 'hE0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nmi_clr_i,
    input logic              mem_rd_o,
    input logic [PC_W-1:0]   mem_addr_o,
    input logic              pc_load_o,
    input logic              done_o,
    input logic              nmi_pend_o,
    input logic [RANK_W-1:0] dbg_rank_o,
    input logic [DATA_W-1:0] dbg_off_o
);

    // R1: the chosen rank is always one of the 16 slots
    assert_rank_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rank_o >= RANK_W'(1)) && (dbg_rank_o <= RANK_W'(MAX_RNK)));

    // R2: the offset is even and inside the vector window
    assert_off_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_off_o[0] && (dbg_off_o >= DATA_W'(LOW_OFF)));

    // R5: the first read of a fetch uses the even address
    assert_even_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !$past(mem_rd_o)) |-> !mem_addr_o[0]);

    // R5: the second read uses the odd neighbour of the first
    assert_odd_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |->
            (mem_addr_o[0] && (mem_addr_o[PC_W-1:1] == $past(mem_addr_o[PC_W-1:1]))));

    // R7: the load lasts exactly one cycle
    assert_load_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !pc_load_o);

    // R7: the load comes two cycles after the last read
    assert_load_after_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> (!$past(mem_rd_o) && $past(mem_rd_o, 2) && done_o));

    // R9: the clear input lowers the flag
    assert_nmi_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_clr_i |=> !nmi_pend_o);

    // R9: without a clear the flag stays raised, a fetch included
    assert_nmi_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend_o && !nmi_clr_i) |=> nmi_pend_o);

endmodule

bind vecfetch_unit vecfetch_unit_chk #(
    .PC_W    (PC_W),
    .DATA_W  (DATA_W),
    .RANK_W  (RANK_W),
    .MAX_RNK (DEF_RANK),
    .LOW_OFF (DEF_OFF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nmi_clr_i  (nmi_clr_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .pc_load_o  (pc_load_o),
    .done_o     (done_o),
    .nmi_pend_o (nmi_pend_o),
    .dbg_rank_o (dbg_rank_o),
    .dbg_off_o  (dbg_off_o)
);

// File: tb/vecfetch_unit_bench.sv
`timescale 1ns/1ps
module vecfetch_unit_bench;

    localparam int          NSRC = 15;
    localparam logic [14:0] RSVD = 15'h3802;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [14:0] req_i = '0;
    logic [15:0] pc_i = '0;
    logic [7:0]  mem_data_i;
    logic        nmi_set_i = 1'b0;
    logic        nmi_clr_i = 1'b0;
    logic        mem_rd_o;
    logic [15:0] mem_addr_o;
    logic        pc_load_o;
    logic [15:0] pc_new_o;
    logic        done_o;
    logic        nmi_pend_o;
    logic [4:0]  dbg_rank_o;
    logic [7:0]  dbg_off_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] seed = 16'hACE1;
    logic [7:0]  mem_q = '0;

    always #2 clk = ~clk;

    vecfetch_unit u_vecfetch_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .req_i      (req_i),
        .pc_i       (pc_i),
        .mem_data_i (mem_data_i),
        .nmi_set_i  (nmi_set_i),
        .nmi_clr_i  (nmi_clr_i),
        .mem_rd_o   (mem_rd_o),
        .mem_addr_o (mem_addr_o),
        .pc_load_o  (pc_load_o),
        .pc_new_o   (pc_new_o),
        .done_o     (done_o),
        .nmi_pend_o (nmi_pend_o),
        .dbg_rank_o (dbg_rank_o),
        .dbg_off_o  (dbg_off_o)
    );

    // Program memory contents as a formula; registered read, one cycle latency
    function automatic logic [7:0] mem_byte(logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_o) mem_q <= mem_byte(mem_addr_o);
    end
    assign mem_data_i = mem_q;

    function automatic int ref_rank(logic [14:0] r);
        for (int i = 0; i < NSRC; i++) begin
            if (r[i] && !RSVD[i]) return i + 1;
        end
        return NSRC + 1;
    endfunction

    function automatic logic [15:0] next_rand(logic [15:0] x);
        logic [15:0] y;
        y = x ^ (x << 7);
        y = y ^ (y >> 9);
        y = y ^ (y << 8);
        return y;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One fetch: start in cycle c, then check each result in the cycle it is due.
    task automatic run_fetch(input logic [14:0] req, input logic [15:0] pc);
        int          er;
        logic [7:0]  eoff;
        logic [15:0] ea;
        logic [15:0] evec;
        string       tg;
        er   = ref_rank(req);
        eoff = 8'(256 - 2 * er);
        ea   = {pc[15:8], eoff};
        evec = {mem_byte(ea), mem_byte(ea | 16'h1)};
        tg   = ((req & RSVD) != 0) ? "R3" : "R1";
        start_i = 1'b1;
        req_i   = req;
        pc_i    = pc;
        @(negedge clk);                                   // c+1
        chk("R7 read 1", 32'(mem_rd_o), 32'd1);
        chk("R5 even addr", 32'(mem_addr_o), 32'(ea));
        chk(tg, 32'(dbg_rank_o), 32'(er));
        chk("R2 offset", 32'(dbg_off_o), 32'(eoff));
        req_i   = ~req;                                   // R4: late change
        pc_i    = ~pc;                                    // R5: late change
        start_i = 1'b1;                                   // R8: strobe while busy
        @(negedge clk);                                   // c+2
        chk("R7 read 2", 32'(mem_rd_o), 32'd1);
        chk("R5 odd addr", 32'(mem_addr_o), 32'(ea | 16'h1));
        chk("R4 rank frozen", 32'(dbg_rank_o), 32'(er));
        @(negedge clk);                                   // c+3
        chk("R7 no read", 32'(mem_rd_o), 32'd0);
        chk("R7 no load yet", 32'(pc_load_o), 32'd0);
        @(negedge clk);                                   // c+4
        chk("R7 load", 32'({pc_load_o, done_o}), 32'd3);
        chk("R6 vector", 32'(pc_new_o), 32'(evec));
        start_i = 1'b0;
        @(negedge clk);                                   // c+5
        chk("R8 no restart", 32'({mem_rd_o, pc_load_o}), 32'd0);
        chk("R4 offset frozen", 32'(dbg_off_o), 32'(eoff));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 outputs", 32'({mem_rd_o, pc_load_o, done_o, nmi_pend_o}), 32'd0);
        chk("R10 rank", 32'(dbg_rank_o), 32'd16);
        chk("R10 offset", 32'(dbg_off_o), 32'hE0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: each possible winner, with assorted lower-ranked bits
        for (int hi = 0; hi <= NSRC; hi++) begin
            for (int k = 0; k < 8; k++) begin
                logic [14:0] r;
                logic [14:0] below;
                seed = next_rand(seed);
                if (hi == NSRC) begin
                    r = (k[0]) ? (seed[14:0] & RSVD) : 15'h0;
                end else begin
                    below = ~((15'h1 << (hi + 1)) - 15'h1);
                    r = (15'h1 << hi) | ((k == 0) ? 15'h0 : (seed[14:0] & below));
                end
                seed = next_rand(seed);
                run_fetch(r, seed);
            end
        end

        // R3: only reserved bits, all of them
        run_fetch(RSVD, 16'h3C00);
        // R2/R1: every request at once, and only the lowest rank
        run_fetch(15'h7FFF, 16'hFF12);
        run_fetch(15'h4000, 16'h0000);

        // R9: pending flag behaviour
        nmi_set_i = 1'b1;
        @(negedge clk);
        nmi_set_i = 1'b0;
        chk("R9 set", 32'(nmi_pend_o), 32'd1);
        run_fetch(15'h0004, 16'h8100);
        chk("R9 kept over fetch", 32'(nmi_pend_o), 32'd1);
        nmi_set_i = 1'b1;
        nmi_clr_i = 1'b1;
        @(negedge clk);
        nmi_set_i = 1'b0;
        nmi_clr_i = 1'b0;
        chk("R9 clear wins", 32'(nmi_pend_o), 32'd0);
        nmi_set_i = 1'b1;
        @(negedge clk);
        nmi_set_i = 1'b0;
        chk("R9 set again", 32'(nmi_pend_o), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 reset clears flag", 32'(nmi_pend_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule